// File: doc/BRIEF.md
# Power Sequence Command Interpreter

The block steps through a table of power-configuration entries and applies each one to a byte-wide register bus. It starts at index zero when pulsed. Each 64-bit entry holds a register offset, a bit mask, a data value and three qualifier masks. The block compares the qualifier masks against the chip's cut, fab and interface identifiers, which arrive on input pins, and skips any entry that does not apply to the present chip. An entry that applies is executed according to its command code.

Five kinds of entry exist. A read does nothing. A write performs a masked read-modify-write of one byte. A poll re-reads one byte until a masked compare succeeds. A delay waits a timed interval in microseconds or milliseconds. An end closes the sequence with success. All polls in one run draw on a single retry budget. When that budget runs out, the run ends with failure. The block derives a microsecond timebase from a clock-frequency parameter.

Top module: `pwr_seq_engine`

## Requirements
- R1: An entry is executed only when (cut mask & cut_id), (fab mask & fab_id) and (interface mask & intf_id) are all nonzero. Any other entry is skipped with no bus access.
- R2: Entry layout on tbl_data: offset [63:48], bit mask [47:40], value [39:32], cut mask [31:24], fab mask [23:16], interface mask [15:8], base [7:4] (ignored), command [3:0]. Command codes: 0 read, 1 write, 2 poll, 3 delay, 4 end.
- R3: A write reads the byte at the offset and writes back (old & ~mask) | (value & mask) to the same offset.
- R4: A poll reads the byte at the offset and moves to the next entry once (byte & mask) == (value & mask).
- R5: After a poll read that does not match, the next read of the same poll starts 9 to 10 microseconds later.
- R6: Poll reads are counted across the whole run, and the count is cleared only by start. The read made when POLL_LIMIT+1 reads have already been counted ends the run with done and ok=0, whatever that read returned.
- R7: A delay waits for offset microsecond ticks when value is 0, and for offset×1000 ticks otherwise. A duration of 0 does not wait.
- R8: An end raises done for exactly one cycle with ok=1, and busy falls in the same cycle.
- R9: A read command, and any command code above 4, makes no bus access. The table index still advances.
- R10: ok holds its last result until the next accepted start, which clears it. A start that arrives while busy is ignored.
- R11: The table is read at tbl_addr while tbl_rd is high, with data valid one cycle later. Each run begins at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run at table index 0 |
| cut_id | input | 8 | Chip cut identifier |
| fab_id | input | 8 | Chip fab identifier |
| intf_id | input | 8 | Host interface identifier |
| tbl_rd | output | 1 | Table read strobe |
| tbl_addr | output | IDX_W | Table index |
| tbl_data | input | 64 | Table entry, valid one cycle after tbl_rd |
| bus_req | output | 1 | Register bus request, held until bus_ack |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | OFS_W | Register offset |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_ack | input | 1 | One-cycle transfer acknowledge |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Result of the last run |

## Verification
A mis-decoded qualifier or command code shows at the ports within a few cycles of the table read: the bus moves when it should stay idle, or stays idle when it should move. A wrong merge shows in the byte written back. A poll counter that is cleared between polls changes the result of a run. That change shows only on the final read of the budget, so the bench spends the budget over two polls and checks how many reads each poll makes. Timebase errors show as run lengths, measured start-to-done, that fall outside a one-tick window.

// File: rtl/pwr_seq_engine.sv
module pwr_seq_engine #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int IDX_W       = 8,
  parameter int OFS_W       = 16,
  parameter int POLL_LIMIT  = 5000,
  parameter int POLL_GAP_US = 10,
  parameter int US_PER_MS   = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       cut_id,
  input  logic [7:0]       fab_id,
  input  logic [7:0]       intf_id,
  output logic             tbl_rd,
  output logic [IDX_W-1:0] tbl_addr,
  input  logic [OFS_W+47:0] tbl_data,
  output logic             bus_req,
  output logic             bus_we,
  output logic [OFS_W-1:0] bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_rdata,
  input  logic             bus_ack,
  output logic             busy,
  output logic             done,
  output logic             ok
);

  localparam int ENT_W = OFS_W + 48;
  localparam int DIV   = (CLK_HZ >= 2_000_000) ? CLK_HZ / 1_000_000 : 2;
  localparam int PW    = $clog2(DIV);
  localparam int PCW   = $clog2(POLL_LIMIT + 2) + 1;
  localparam int WW    = 32;

  localparam logic [3:0] C_READ  = 4'd0;
  localparam logic [3:0] C_WRITE = 4'd1;
  localparam logic [3:0] C_POLL  = 4'd2;
  localparam logic [3:0] C_DELAY = 4'd3;
  localparam logic [3:0] C_END   = 4'd4;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LATCH, S_READ, S_WRITE, S_WAIT} st_t;

  st_t              state;
  logic [IDX_W-1:0] idx;
  logic [OFS_W-1:0] ofs_q;
  logic [7:0]       mask_q, val_q, wdata_q;
  logic [3:0]       cmd_q;
  logic [PCW-1:0]   pcnt;
  logic [WW-1:0]    wcnt, wtgt;
  logic             poll_wait, done_q, ok_q;
  logic [PW-1:0]    pre;

  wire [OFS_W-1:0] t_ofs  = tbl_data[ENT_W-1:48];
  wire [7:0]       t_mask = tbl_data[47:40];
  wire [7:0]       t_val  = tbl_data[39:32];
  wire [3:0]       t_cmd  = tbl_data[3:0];
  wire             t_sel  = |(tbl_data[31:24] & cut_id) &&
                            |(tbl_data[23:16] & fab_id) &&
                            |(tbl_data[15:8]  & intf_id);
  wire             unused_base_bits = ^tbl_data[7:4];

  wire us_tick   = (pre == PW'(DIV - 1));
  wire poll_hit  = ((bus_rdata & mask_q) == (val_q & mask_q));
  wire [WW-1:0] dly_us = WW'(t_ofs);
  wire [WW-1:0] dly_ms = WW'(t_ofs) * WW'(US_PER_MS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= us_tick ? '0 : pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      ofs_q     <= '0;
      mask_q    <= '0;
      val_q     <= '0;
      cmd_q     <= '0;
      wdata_q   <= '0;
      pcnt      <= '0;
      wcnt      <= '0;
      wtgt      <= '0;
      poll_wait <= 1'b0;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          idx   <= '0;
          pcnt  <= '0;
          ok_q  <= 1'b0;
          state <= S_FETCH;
        end
        S_FETCH: state <= S_LATCH;
        S_LATCH: begin
          ofs_q     <= t_ofs;
          mask_q    <= t_mask;
          val_q     <= t_val;
          cmd_q     <= t_cmd;
          poll_wait <= 1'b0;
          if (!t_sel) begin
            idx   <= idx + 1'b1;
            state <= S_FETCH;
          end else begin
            case (t_cmd)
              C_WRITE, C_POLL: state <= S_READ;
              C_DELAY: begin
                wcnt <= '0;
                wtgt <= (t_val == 8'd0) ? dly_us : dly_ms;
                if (t_ofs == '0) begin
                  idx   <= idx + 1'b1;
                  state <= S_FETCH;
                end else begin
                  state <= S_WAIT;
                end
              end
              C_END: begin
                ok_q   <= 1'b1;
                done_q <= 1'b1;
                state  <= S_IDLE;
              end
              default: begin
                idx   <= idx + 1'b1;
                state <= S_FETCH;
              end
            endcase
          end
        end
        S_READ: if (bus_ack) begin
          if (cmd_q == C_WRITE) begin
            wdata_q <= (bus_rdata & ~mask_q) | (val_q & mask_q);
            state   <= S_WRITE;
          end else if (pcnt > PCW'(POLL_LIMIT)) begin
            ok_q   <= 1'b0;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            pcnt <= pcnt + 1'b1;
            if (poll_hit) begin
              idx   <= idx + 1'b1;
              state <= S_FETCH;
            end else begin
              poll_wait <= 1'b1;
              wcnt      <= '0;
              wtgt      <= WW'(POLL_GAP_US);
              state     <= S_WAIT;
            end
          end
        end
        S_WRITE: if (bus_ack) begin
          idx   <= idx + 1'b1;
          state <= S_FETCH;
        end
        S_WAIT: if (us_tick) begin
          if (wcnt + 1'b1 == wtgt) begin
            if (poll_wait) state <= S_READ;
            else begin
              idx   <= idx + 1'b1;
              state <= S_FETCH;
            end
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign tbl_rd    = (state == S_FETCH);
  assign tbl_addr  = idx;
  assign bus_req   = (state == S_READ) || (state == S_WRITE);
  assign bus_we    = (state == S_WRITE);
  assign bus_addr  = ofs_q;
  assign bus_wdata = wdata_q;
  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign ok        = ok_q;

  assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !tbl_rd));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ok_rises_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> (done && !busy));

  assert_merge_keeps_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> ((bus_wdata & mask_q) == (val_q & mask_q)));

  assert_budget_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PCW'(POLL_LIMIT + 1));

  assert_wait_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> (wcnt < wtgt));

  assert_ok_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !done) |=> $stable(ok));

endmodule

// File: tb/tb_pwr_seq_engine.sv
module tb_pwr_seq_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cut_id = 8'h04, fab_id = 8'h01, intf_id = 8'h02;
  logic        tbl_rd;
  logic [7:0]  tbl_addr;
  logic [63:0] tbl_data;
  logic        bus_req, bus_we, bus_ack;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        busy, done, ok;

  always #10 clk = ~clk;

  pwr_seq_engine #(.POLL_LIMIT(4)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cut_id(cut_id), .fab_id(fab_id), .intf_id(intf_id),
    .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .busy(busy), .done(done), .ok(ok));

  logic [63:0] tbl [0:15];
  always @(posedge clk) if (tbl_rd) tbl_data <= tbl[tbl_addr[3:0]];

  logic [7:0]  regs [0:255];
  logic        pre_we = 1'b0;
  logic [7:0]  pre_addr = 8'h0, pre_data = 8'h0;
  int          cyc = 0, acc = 0, f0_reads = 0, f1_reads = 0, f0_base = 0, flip_k = 0;
  int          rd_t [0:7];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pre_we) regs[pre_addr] <= pre_data;
    if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      acc <= acc + 1;
      if (bus_we) regs[bus_addr[7:0]] <= bus_wdata;
      else if (bus_addr[7:0] == 8'hF0) begin
        bus_rdata <= ((f0_reads - f0_base) >= flip_k) ? 8'hA5 : 8'h05;
        rd_t[f0_reads[2:0]] <= cyc;
        f0_reads <= f0_reads + 1;
      end else if (bus_addr[7:0] == 8'hF1) begin
        bus_rdata <= 8'h00;
        f1_reads <= f1_reads + 1;
      end else bus_rdata <= regs[bus_addr[7:0]];
    end else bus_ack <= 1'b0;
  end

  int n_tests = 0, n_fail = 0;

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ent(input logic [15:0] o, input logic [7:0] m, v,
                                      cm, fm, im, input logic [3:0] c);
    return {o, m, v, cm, fm, im, 4'h0, c};
  endfunction

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); pre_we = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk); pre_we = 1'b0;
  endtask

  task automatic run(output int n);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 1;
    while (!done && n < 120000) begin @(negedge clk); n++; end
  endtask

  localparam int NV = 8;
  localparam logic [55:0] VEC [0:NV-1] = '{
    {8'h00, 8'hFF, 8'h5A, 8'hFF, 8'hFF, 8'hFF, 8'h5A},
    {8'hF0, 8'h0F, 8'h33, 8'hFF, 8'hFF, 8'hFF, 8'hF3},
    {8'hAA, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hAA},
    {8'h3C, 8'hC3, 8'h81, 8'hFF, 8'hFF, 8'hFF, 8'hBD},
    {8'h11, 8'hFF, 8'h22, 8'h03, 8'hFF, 8'hFF, 8'h11},
    {8'h11, 8'hFF, 8'h22, 8'hFF, 8'h02, 8'hFF, 8'h11},
    {8'h11, 8'hFF, 8'h22, 8'hFF, 8'hFF, 8'h01, 8'h11},
    {8'h11, 8'hFF, 8'h22, 8'h04, 8'h01, 8'h02, 8'h22}
  };

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 190000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<190000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int n, a0, g;
    bus_ack = 1'b0; bus_rdata = 8'h00;
    for (int i = 0; i < 16; i++) tbl[i] = ent(16'h0, 8'h0, 8'h0, 8'hFF, 8'hFF, 8'hFF, 4'd4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !ok && !bus_req && !tbl_rd, "R11 reset", {busy, done, ok, bus_req, tbl_rd}, 0);

    // R1 R3 R2 vector loop
    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      v = VEC[i];
      tbl[0] = ent(16'h0010, v[47:40], v[39:32], v[31:24], v[23:16], v[15:8], 4'd1);
      tbl[1] = ent(16'h0, 8'h0, 8'h0, 8'hFF, 8'hFF, 8'hFF, 4'd4);
      poke(8'h10, v[55:48]);
      a0 = acc;
      run(n);
      @(negedge clk);
      check(regs[8'h10] == v[7:0], "R3 merge", regs[8'h10], v[7:0]);
      check(ok == 1'b1, "R8 ok after end", ok, 1);
      if (v[55:48] == 8'h11 && v[7:0] == 8'h11)
        check(acc == a0, "R1 filtered entry no bus access", acc - a0, 0);
    end
    check(done == 1'b0, "R8 done one cycle", done, 0);
    check(ok == 1'b1, "R10 ok held", ok, 1);

    // R9 read and unknown commands
    tbl[0] = ent(16'h0020, 8'hFF, 8'h11, 8'hFF, 8'hFF, 8'hFF, 4'd0);
    tbl[1] = ent(16'h0020, 8'hFF, 8'h22, 8'hFF, 8'hFF, 8'hFF, 4'd7);
    tbl[2] = ent(16'h0020, 8'hFF, 8'h9C, 8'hFF, 8'hFF, 8'hFF, 4'd1);
    tbl[3] = ent(16'h0, 8'h0, 8'h0, 8'hFF, 8'hFF, 8'hFF, 4'd4);
    poke(8'h20, 8'h00);
    a0 = acc;
    run(n);
    check(acc - a0 == 2, "R9 only write entry touches bus", acc - a0, 2);
    check(regs[8'h20] == 8'h9C, "R9 index advanced past read/unknown", regs[8'h20], 8'h9C);

    // R4 R5 poll success after two misses
    tbl[0] = ent(16'h00F0, 8'hF0, 8'hA0, 8'hFF, 8'hFF, 8'hFF, 4'd2);
    tbl[1] = ent(16'h0, 8'h0, 8'h0, 8'hFF, 8'hFF, 8'hFF, 4'd4);
    flip_k = 2; f0_base = f0_reads;
    run(n);
    check(f0_reads - f0_base == 3, "R4 poll reads", f0_reads - f0_base, 3);
    check(ok == 1'b1, "R4 poll ok", ok, 1);
    g = rd_t[(f0_base + 1) % 8] - rd_t[f0_base % 8];
    check(g >= 450 && g <= 510, "R5 retry gap", g, 500);
    g = rd_t[(f0_base + 2) % 8] - rd_t[(f0_base + 1) % 8];
    check(g >= 450 && g <= 510, "R5 retry gap 2", g, 500);

    // R6 budget shared by two polls
    tbl[0] = ent(16'h00F0, 8'hF0, 8'hA0, 8'hFF, 8'hFF, 8'hFF, 4'd2);
    tbl[1] = ent(16'h00F1, 8'hFF, 8'h77, 8'hFF, 8'hFF, 8'hFF, 4'd2);
    tbl[2] = ent(16'h0030, 8'hFF, 8'h11, 8'hFF, 8'hFF, 8'hFF, 4'd1);
    tbl[3] = ent(16'h0, 8'h0, 8'h0, 8'hFF, 8'hFF, 8'hFF, 4'd4);
    poke(8'h30, 8'h00);
    a0 = f1_reads; f0_base = f0_reads;
    run(n);
    check(done && !ok, "R6 budget exhausted fails", ok, 0);
    check(f1_reads - a0 == 3, "R6 second poll reads", f1_reads - a0, 3);
    check(regs[8'h30] == 8'h00, "R6 no further entries", regs[8'h30], 0);

    // R6 R10 budget cleared by start
    tbl[1] = ent(16'h0, 8'h0, 8'h0, 8'hFF, 8'hFF, 8'hFF, 4'd4);
    f0_base = f0_reads;
    run(n);
    check(ok == 1'b1, "R6 budget cleared at start", ok, 1);

    // R7 microsecond delay
    tbl[0] = ent(16'd20, 8'h0, 8'h00, 8'hFF, 8'hFF, 8'hFF, 4'd3);
    run(n);
    check(n >= 950 && n <= 1010, "R7 us delay", n, 1000);

    // R7 zero duration
    tbl[0] = ent(16'd0, 8'h0, 8'h00, 8'hFF, 8'hFF, 8'hFF, 4'd3);
    run(n);
    check(n <= 10, "R7 zero delay", n, 5);

    // R10 start clears ok, start while busy ignored
    tbl[0] = ent(16'd20, 8'h0, 8'h00, 8'hFF, 8'hFF, 8'hFF, 4'd3);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(ok == 1'b0 && busy == 1'b1, "R10 start clears ok", ok, 0);
    n = 1;
    repeat (300) begin @(negedge clk); n++; end
    start = 1'b1; @(negedge clk); start = 1'b0; n++;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(n >= 950 && n <= 1010, "R10 restart while busy ignored", n, 1000);

    // R7 millisecond delay
    tbl[0] = ent(16'd1, 8'h0, 8'h01, 8'hFF, 8'hFF, 8'hFF, 4'd3);
    run(n);
    check(n >= 49950 && n <= 50010, "R7 ms delay", n, 50000);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule